// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Controller

This block serves an eight-line digital port on a byte-wide register bus. It brings the input lines into the clock domain through a two-stage synchroniser and drives the output lines from a register that software can read back. Each input line can latch a pending interrupt on a rising edge or on a falling edge. Software chooses the edge per line.

A pending bit becomes visible in the status register only while that line is enabled. Software clears it by writing a one to it. Two processors each own a mask register. Each processor has a read-only source view equal to pending AND enable AND its own mask, and an interrupt output that is the OR of that view.

Edge detection works on a per-line qualified level: the synchronised input when rising is selected, and its inverse when falling is selected. A new event is a rise of that level. As a result, rewriting the polarity while a line is static can raise a pending bit, and software is expected to clear it. The route and control bytes are plain storage.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0x00, `line_out` is 0x00 and both `cpu_irq` bits are 0.
- R2: Bytes written to output data (0x104), route (0x100) and control (0x101) read back unchanged. The output data byte drives `line_out` from the clock edge that takes the write.
- R3: Input data (0x103) shows `line_in` two clock edges after the input changes, and not earlier.
- R4: With edge bit = 1, a 0-to-1 transition of a line sets its pending bit. A 1-to-0 transition leaves the bit unchanged.
- R5: With edge bit = 0, a 1-to-0 transition of a line sets its pending bit.
- R6: Status (0x262) reads pending AND enable (0x252). A pending bit of a disabled line is kept, and it appears as soon as the line is enabled.
- R7: Writing status with a 1 in a bit clears that pending bit. A 0 in a bit leaves it unchanged.
- R8: If a new event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R9: Rewriting an edge bit so that the line's qualified level goes from inactive to active sets the pending bit. This happens for a low line switched from rising to falling, and for a high line switched from falling to rising.
- R10: Processor k has a mask at 0x280+k and a read-only source at 0x290+k. The source equals pending AND enable AND mask k.
- R11: `cpu_irq[k]` is 1 exactly when source k is non-zero.
- R12: Reads of unmapped addresses return 0x00. Writes to unmapped addresses, to input data and to the source registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Write strobe, taken at the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, a combinational function of `reg_addr` |
| line_in | input | 8 | Asynchronous input lines |
| line_out | output | 8 | Output data lines |
| cpu_irq | output | 2 | One interrupt request per processor |

## Verification
The assertions assume that `reg_addr`, `reg_wr` and `reg_wdata` are stable around each rising clock edge, and that `line_in` holds for at least one clock. The synchroniser check also assumes that a pin value is captured intact by the first stage. The bench changes every bus and pin input on the falling edge and holds each pin pattern for several cycles. This keeps every transition a clean single edge that the synchroniser sees once.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int LINES = 8;
  localparam int CPUS  = 2;
  localparam int AW    = 12;

  localparam logic [AW-1:0] A_ROUTE = 12'h100;
  localparam logic [AW-1:0] A_CTRL  = 12'h101;
  localparam logic [AW-1:0] A_DIN   = 12'h103;
  localparam logic [AW-1:0] A_DOUT  = 12'h104;
  localparam logic [AW-1:0] A_EDGE  = 12'h202;
  localparam logic [AW-1:0] A_IEN   = 12'h252;
  localparam logic [AW-1:0] A_IST   = 12'h262;
  localparam logic [AW-1:0] A_MASK0 = 12'h280;
  localparam logic [AW-1:0] A_SRC0  = 12'h290;

  // level that an event arms on: the input itself for rising, inverted for falling
  function automatic logic qual_level(logic s, logic rise_sel);
    return rise_sel ? s : ~s;
  endfunction

  function automatic logic arm_event(logic lvl, logic lvl_prev);
    return lvl & ~lvl_prev;
  endfunction

  // a fresh event outranks a clear in the same cycle
  function automatic logic pend_next(logic p, logic clr, logic ev);
    return (p & ~clr) | ev;
  endfunction

  function automatic logic route_bit(logic p, logic en, logic m);
    return p & en & m;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N = gpio_irq_pkg::LINES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] sync
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic st1, st2;
    always_ff @(posedge clk) begin
      if (rst) begin
        st1 <= 1'b0;
        st2 <= 1'b0;
      end else begin
        st1 <= raw[i];
        st2 <= st1;
      end
    end
    assign sync[i] = st2;
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R3: two-stage latency from pin to synchronised value
  a_r3_two_stage: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (sync == $past(raw, 2)));
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int N = gpio_irq_pkg::LINES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sync,
  input  logic [N-1:0] rise_sel,
  output logic [N-1:0] evt
);
  import gpio_irq_pkg::*;

  logic [N-1:0] lvl;
  logic [N-1:0] lvl_prev;

  for (genvar i = 0; i < N; i++) begin : g_det
    assign lvl[i] = qual_level(sync[i], rise_sel[i]);
    assign evt[i] = arm_event(lvl[i], lvl_prev[i]);
    // reset value matches a low line with falling selected, so no event at release
    always_ff @(posedge clk) begin
      if (rst) lvl_prev[i] <= 1'b1;
      else     lvl_prev[i] <= lvl[i];
    end
  end

  // R4/R9: an event needs a change of the input or of the edge selection
  a_r4_event_has_cause: assert property (@(posedge clk) disable iff (rst)
    (|evt) |-> ((sync != $past(sync)) || (rise_sel != $past(rise_sel))));
endmodule

// File: rtl/gpio_pend_reg.sv
module gpio_pend_reg #(
  parameter int N = gpio_irq_pkg::LINES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  import gpio_irq_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) pend[i] <= 1'b0;
      else     pend[i] <= pend_next(pend[i], clr[i], evt[i]);
    end
  end

  a_r7_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (|(clr & ~evt)) |=> ((pend & $past(clr & ~evt)) == '0));

  a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((pend & $past(evt)) == $past(evt)));
endmodule

// File: rtl/gpio_cpu_route.sv
module gpio_cpu_route #(
  parameter int N  = gpio_irq_pkg::LINES,
  parameter int NC = gpio_irq_pkg::CPUS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NC-1:0]         mask_wr,
  input  logic [N-1:0]          wdata,
  input  logic [N-1:0]          pend,
  input  logic [N-1:0]          en,
  output logic [NC-1:0][N-1:0]  mask,
  output logic [NC-1:0][N-1:0]  src,
  output logic [NC-1:0]         irq
);
  import gpio_irq_pkg::*;

  for (genvar k = 0; k < NC; k++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (rst)             mask[k] <= '0;
      else if (mask_wr[k]) mask[k] <= wdata;
    end
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign src[k][i] = route_bit(pend[i], en[i], mask[k][i]);
    end
    assign irq[k] = |src[k];

    // R10: nothing outside the processor's mask reaches its source view
    a_r10_src_in_mask: assert property (@(posedge clk) disable iff (rst)
      (src[k] & ~mask[k]) == '0);
  end

  // R11: no request without a pending, enabled line
  a_r11_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    ((pend & en) == '0) |-> (irq == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NLINES = gpio_irq_pkg::LINES,
  parameter int NCPU   = gpio_irq_pkg::CPUS,
  parameter int AW     = gpio_irq_pkg::AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wr,
  input  logic [NLINES-1:0] reg_wdata,
  output logic [NLINES-1:0] reg_rdata,
  input  logic [NLINES-1:0] line_in,
  output logic [NLINES-1:0] line_out,
  output logic [NCPU-1:0]   cpu_irq
);
  import gpio_irq_pkg::*;

  logic [NLINES-1:0] route_q, ctrl_q, dout_q, edge_q, ien_q;
  logic [NLINES-1:0] sync_in, evt, pend, clr;
  logic [NCPU-1:0]   mask_wr;
  logic [NCPU-1:0][NLINES-1:0] mask, src;

  logic wr_route, wr_ctrl, wr_dout, wr_edge, wr_ien, wr_ist;
  assign wr_route = reg_wr && (reg_addr == A_ROUTE);
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_dout  = reg_wr && (reg_addr == A_DOUT);
  assign wr_edge  = reg_wr && (reg_addr == A_EDGE);
  assign wr_ien   = reg_wr && (reg_addr == A_IEN);
  assign wr_ist   = reg_wr && (reg_addr == A_IST);
  assign clr      = wr_ist ? reg_wdata : '0;

  for (genvar k = 0; k < NCPU; k++) begin : g_mwr
    assign mask_wr[k] = reg_wr && (reg_addr == AW'(A_MASK0 + k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q <= '0;
      ctrl_q  <= '0;
      dout_q  <= '0;
      edge_q  <= '0;
      ien_q   <= '0;
    end else begin
      if (wr_route) route_q <= reg_wdata;
      if (wr_ctrl)  ctrl_q  <= reg_wdata;
      if (wr_dout)  dout_q  <= reg_wdata;
      if (wr_edge)  edge_q  <= reg_wdata;
      if (wr_ien)   ien_q   <= reg_wdata;
    end
  end

  gpio_in_sync #(.N(NLINES)) u_sync (
    .clk(clk), .rst(rst), .raw(line_in), .sync(sync_in)
  );

  gpio_edge_det #(.N(NLINES)) u_edge (
    .clk(clk), .rst(rst), .sync(sync_in), .rise_sel(edge_q), .evt(evt)
  );

  gpio_pend_reg #(.N(NLINES)) u_pend (
    .clk(clk), .rst(rst), .evt(evt), .clr(clr), .pend(pend)
  );

  gpio_cpu_route #(.N(NLINES), .NC(NCPU)) u_route (
    .clk(clk), .rst(rst), .mask_wr(mask_wr), .wdata(reg_wdata),
    .pend(pend), .en(ien_q), .mask(mask), .src(src), .irq(cpu_irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_ROUTE) reg_rdata = route_q;
    if (reg_addr == A_CTRL)  reg_rdata = ctrl_q;
    if (reg_addr == A_DIN)   reg_rdata = sync_in;
    if (reg_addr == A_DOUT)  reg_rdata = dout_q;
    if (reg_addr == A_EDGE)  reg_rdata = edge_q;
    if (reg_addr == A_IEN)   reg_rdata = ien_q;
    if (reg_addr == A_IST)   reg_rdata = pend & ien_q;
    for (int k = 0; k < NCPU; k++) begin
      if (reg_addr == AW'(A_MASK0 + k)) reg_rdata = mask[k];
      if (reg_addr == AW'(A_SRC0 + k))  reg_rdata = src[k];
    end
  end

  assign line_out = dout_q;

  // R2: output lines move only on a write to the output data byte
  a_r2_dout_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_dout |=> $stable(line_out));
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [7:0]  line_in = '0;
  logic [7:0]  line_out;
  logic [1:0]  cpu_irq;

  always #2 clk = ~clk;

  gpio_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_in(line_in),
    .line_out(line_out), .cpu_irq(cpu_irq)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // scoreboard: kind 0 = read data, 1 = irq pins, 2 = output lines
  int         q_kind[$];
  logic [7:0] q_exp[$];
  string      q_tag[$];
  event       ev_smp;

  always begin
    @(ev_smp);
    begin
      int k;
      logic [7:0] e, a;
      string t;
      k = q_kind.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      a = (k == 0) ? reg_rdata : (k == 1) ? {6'b0, cpu_irq} : line_out;
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s actual=%02h expected=%02h", t, a, e);
      end
    end
  end

  task automatic expect_rd(input logic [11:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    reg_addr = a;
    q_kind.push_back(0); q_exp.push_back(e); q_tag.push_back(t);
    #1 -> ev_smp;
  endtask

  task automatic expect_pin(input int k, input logic [7:0] e, input string t);
    @(negedge clk);
    q_kind.push_back(k); q_exp.push_back(e); q_tag.push_back(t);
    #1 -> ev_smp;
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk);
    line_in = v;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    expect_rd(12'h100, 8'h00, "R1 route");
    expect_rd(12'h104, 8'h00, "R1 dout");
    expect_rd(12'h202, 8'h00, "R1 edge");
    expect_rd(12'h252, 8'h00, "R1 ien");
    expect_rd(12'h262, 8'h00, "R1 ist");
    expect_rd(12'h280, 8'h00, "R1 mask0");
    expect_pin(1, 8'h00, "R1 irq");
    expect_pin(2, 8'h00, "R1 line_out");

    // R2 storage and output lines
    wr(12'h104, 8'hA5);
    expect_rd(12'h104, 8'hA5, "R2 dout readback");
    expect_pin(2, 8'hA5, "R2 line_out");
    wr(12'h100, 8'h3C);
    wr(12'h101, 8'h81);
    expect_rd(12'h100, 8'h3C, "R2 route");
    expect_rd(12'h101, 8'h81, "R2 ctrl");

    // R12 ignored writes and unmapped reads
    wr(12'h103, 8'hFF);
    expect_rd(12'h103, 8'h00, "R12 din write ignored");
    wr(12'h105, 8'h55);
    expect_rd(12'h105, 8'h00, "R12 unmapped");
    wr(12'h290, 8'hFF);
    expect_rd(12'h290, 8'h00, "R12 src write ignored");

    // R3 synchroniser latency
    set_pins(8'h5A);
    expect_rd(12'h103, 8'h00, "R3 one edge old");
    expect_rd(12'h103, 8'h5A, "R3 two edges new");
    settle();
    wr(12'h252, 8'hFF);
    expect_rd(12'h262, 8'h00, "R5 rising ignored on falling");

    // R9 polarity rewrite on high lines
    wr(12'h202, 8'hFF);
    settle();
    expect_rd(12'h262, 8'h5A, "R9 falling->rising high lines");
    wr(12'h262, 8'hFF);
    expect_rd(12'h262, 8'h00, "R7 clear all");

    // R4 rising edges
    set_pins(8'hFF);
    settle();
    expect_rd(12'h262, 8'hA5, "R4 rising");
    set_pins(8'h0F);
    settle();
    expect_rd(12'h262, 8'hA5, "R4 falling ignored");
    wr(12'h262, 8'h05);
    expect_rd(12'h262, 8'hA0, "R7 partial clear");

    // R9 polarity rewrite on low lines, then R5
    wr(12'h202, 8'h00);
    settle();
    expect_rd(12'h262, 8'hF0, "R9 rising->falling low lines");
    wr(12'h262, 8'hFF);
    set_pins(8'h00);
    settle();
    expect_rd(12'h262, 8'h0F, "R5 falling");
    wr(12'h262, 8'hFF);

    // R6 hidden pending
    wr(12'h252, 8'h00);
    set_pins(8'h0F);
    settle();
    set_pins(8'h00);
    settle();
    expect_rd(12'h262, 8'h00, "R6 hidden when disabled");
    wr(12'h252, 8'h03);
    expect_rd(12'h262, 8'h03, "R6 partial enable");
    wr(12'h252, 8'hFF);
    expect_rd(12'h262, 8'h0F, "R6 held pending");

    // R10 / R11 routing
    wr(12'h280, 8'h01);
    wr(12'h281, 8'h0C);
    expect_rd(12'h280, 8'h01, "R10 mask0");
    expect_rd(12'h290, 8'h01, "R10 src0");
    expect_rd(12'h291, 8'h0C, "R10 src1");
    expect_pin(1, 8'h03, "R11 both irq");
    wr(12'h281, 8'h30);
    expect_rd(12'h291, 8'h00, "R10 src1 masked");
    expect_pin(1, 8'h01, "R11 cpu0 only");
    wr(12'h252, 8'h0E);
    expect_rd(12'h290, 8'h00, "R10 src0 disabled");
    expect_pin(1, 8'h00, "R11 none");
    wr(12'h252, 8'hFF);
    wr(12'h262, 8'hFF);
    expect_pin(1, 8'h00, "R11 after clear");

    // R8 event and clear in the same cycle
    set_pins(8'h03);
    settle();
    set_pins(8'h01);
    settle();
    expect_rd(12'h262, 8'h02, "R5 line1 falling");
    set_pins(8'h00);
    @(negedge clk);
    wr(12'h262, 8'h03);
    settle();
    expect_rd(12'h262, 8'h01, "R8 event wins over clear");
    expect_pin(1, 8'h01, "R11 cpu0 from line0");

    settle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule